// File: doc/BRIEF.md
# Sensor Startup and Sampling Sequencer

This controller sits above a serial frame transactor and runs an accelerometer-class sensor without software help. When reset is released it commands a soft reset, waits out the settling time and checks the identity register. It then raises either a ready flag or a failure flag. Once ready, each trigger pulse reads the enabled channels in ascending order into a sample record. A one-cycle strobe marks a complete record.

Every access goes to the transactor through a request/done handshake. The request is held until done is pulsed, and done comes with a two-bit return status, a 16-bit read word and a checksum-error flag. When a return status of 3 comes back, the sequencer reads the status register to clear the condition and reports the low 9 bits of that register.

Configuration arrives as commands held by `cmd_valid`. A command is either a raw register write, a mode selection or a low-pass filter selection. Commands that are not allowed finish with a reject pulse and issue no access.

Top module: `sensor_seq`

## Requirements
- R1: After reset the first access is a write of 0x0020 to register 0x0D.
- R2: The identity read is not requested until the request line has been low for at least CLK_KHZ*SETTLE_MS cycles after the reset write completes.
- R3: The identity read targets register 0x10. `init_ok` rises only if bits 7:0 equal 0x51, the return status is not 3 and there is no checksum error. Otherwise `init_fail` rises, and after that no trigger or command starts any access.
- R4: When ready and idle, a trigger with a non-zero `chan_en` reads channel i from address CH_BASE+i for each set bit, lowest index first. `smp_valid` then pulses for one cycle. Slot i (`smp_data` bits 16i+15:16i) holds the word read for an enabled channel and zero for a disabled one. A trigger with `chan_en` of zero does nothing.
- R5: An access that returns status 3 with a good checksum is followed by a read of register 0x06. `err_valid` then pulses with `err_status` equal to bits 8:0 of the word read. A scan hit by this reads no further channels and gives no `smp_valid`.
- R6: A checksum error during a scan abandons the scan with no `smp_valid` and no status read.
- R7: A trigger arriving while startup, a scan, a command or a status read is in progress starts nothing. It adds one to `overrun_cnt`, which saturates.
- R8: `cmd_op` 0 writes `cmd_data` to `cmd_addr`. An address above 0x1F, or `cmd_op` 3, is answered with `cmd_rej` and no access. An accepted command ends with `cmd_done`.
- R9: `cmd_op` 1 writes `cmd_data` to register 0x0D if the value is 0 to 3. Any other value is rejected.
- R10: `cmd_op` 2 with `cmd_data[0]`=1 writes 3 to 0x0D, and is allowed only in mode 2. With `cmd_data[0]`=0 it writes 2, and is allowed only in mode 3. Any other case is rejected. The mode is 0 after startup and follows only writes of 0 to 3 to 0x0D that complete without error.
- R11: During and right after reset, `init_ok`, `init_fail`, `smp_valid`, `err_valid` and `overrun_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Scan trigger pulse |
| chan_en | input | N_CH | Enabled channel mask |
| cmd_valid | input | 1 | Command held until done or reject |
| cmd_op | input | 2 | 0 reg write, 1 mode, 2 filter, 3 reserved |
| cmd_addr | input | 8 | Register address for op 0 |
| cmd_data | input | 16 | Write value or filter choice |
| cmd_done | output | 1 | Command access finished |
| cmd_rej | output | 1 | Command refused, no access |
| xact_req | output | 1 | Access request to transactor |
| xact_wr | output | 1 | Access is a write |
| xact_addr | output | 5 | Register address |
| xact_wdata | output | 16 | Write word |
| xact_done | input | 1 | Access completed |
| xact_rs | input | 2 | Returned status |
| xact_rdata | input | 16 | Returned word |
| xact_crc_err | input | 1 | Returned frame failed its checksum |
| init_ok | output | 1 | Startup succeeded |
| init_fail | output | 1 | Startup failed |
| smp_valid | output | 1 | Sample record complete |
| smp_data | output | 16*N_CH | Sample record, slot i at bits 16i+15:16i |
| err_valid | output | 1 | Device status reported |
| err_status | output | 9 | Low bits of device status |
| overrun_cnt | output | OVR_W | Dropped trigger count |

## Verification
Every one of the sixteen channel masks is scanned with a distinct data seed. This shows whether the order is correct, whether disabled slots are cleared and whether the empty mask is really ignored. Error returns are placed on a middle channel and on a later one: a status-3 return separates a status read with truncation from a checksum failure, which must not read the status. The command sequence walks modes 0, 2 and 3, including a write that fails. This shows whether filter permission follows the mode of the last successful write. A second startup with a wrong identity shows whether the failed state stays locked.

// File: rtl/sseq_pkg.sv
// Shared constants and types for the sensor sequencer.
// Assumes a 5-bit register address space and 16-bit data words.
package sseq_pkg;
    localparam int ADDR_W = 5;
    localparam int WORD_W = 16;
    localparam int STAT_W = 9;

    localparam logic [ADDR_W-1:0] A_MODE  = 5'h0D;
    localparam logic [ADDR_W-1:0] A_STAT  = 5'h06;
    localparam logic [ADDR_W-1:0] A_IDENT = 5'h10;

    localparam logic [WORD_W-1:0] SOFT_RST_CODE = 16'h0020;
    localparam logic [7:0]        IDENT_CODE    = 8'h51;
    localparam logic [1:0]        RS_ERROR      = 2'b11;

    typedef enum logic [2:0] {
        ST_BOOT, ST_SETTLE, ST_IDENT, ST_IDLE,
        ST_SCAN, ST_CMD, ST_STAT, ST_DEAD
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_REGWR = 2'd0, OP_MODE = 2'd1, OP_FILT = 2'd2, OP_RSVD = 2'd3
    } cmd_op_t;
endpackage

// File: rtl/settle_timer.sv
// Settling timer: counts while enabled and fires in the CYCLES-th enabled cycle.
// Assumes en stays high until fire is seen; dropping en clears the count.
module settle_timer #(
    parameter int CYCLES = 1600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic fire
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;

    assign fire = en && (cnt == CW'(CYCLES - 1));

    // Count enabled cycles, restart whenever disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (!en)   cnt <= '0;
        else if (!fire) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/chan_pick.sv
// Lowest-index picker over the pending channel mask.
// Outputs a one-hot grant and its binary index; pure combinational.
module chan_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]                      pend,
    output logic [N-1:0]                      grant,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N:0] seen;
    assign seen[0] = 1'b0;

    // Priority chain: a bit wins only if no lower bit is pending.
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g]    = pend[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | pend[g];
    end

    // Encode the winning position.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) idx = IW'(i);
    end
endmodule

// File: rtl/sensor_seq.sv
// Sensor startup and sampling sequencer.
// Runs reset/settle/identity startup, then scans enabled channels per trigger,
// executes configuration commands and recovers from error returns by a status read.
// Assumes the transactor holds xact_done high for exactly one cycle per request.
module sensor_seq
    import sseq_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int CH_BASE   = 1,
    parameter int CLK_KHZ   = 100000,
    parameter int SETTLE_MS = 16,
    parameter int OVR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig,
    input  logic [N_CH-1:0]       chan_en,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [7:0]            cmd_addr,
    input  logic [15:0]           cmd_data,
    output logic                  cmd_done,
    output logic                  cmd_rej,
    output logic                  xact_req,
    output logic                  xact_wr,
    output logic [4:0]            xact_addr,
    output logic [15:0]           xact_wdata,
    input  logic                  xact_done,
    input  logic [1:0]            xact_rs,
    input  logic [15:0]           xact_rdata,
    input  logic                  xact_crc_err,
    output logic                  init_ok,
    output logic                  init_fail,
    output logic                  smp_valid,
    output logic [16*N_CH-1:0]    smp_data,
    output logic                  err_valid,
    output logic [8:0]            err_status,
    output logic [OVR_W-1:0]      overrun_cnt
);
    localparam int WAIT_CYC = CLK_KHZ * SETTLE_MS;
    localparam int IW       = (N_CH > 1) ? $clog2(N_CH) : 1;

    seq_state_t                    state;
    logic [N_CH-1:0]               pend;
    logic [N_CH-1:0]               grant;
    logic [IW-1:0]                 idx;
    logic [N_CH-1:0][WORD_W-1:0]   smp_q;
    logic [1:0]                    mode_q;
    logic [ADDR_W-1:0]             cmd_tgt_q;
    logic [WORD_W-1:0]             cmd_wd_q;
    logic                          settle_fire;

    // Command decode results
    cmd_op_t                       op;
    logic                          cmd_ok;
    logic [ADDR_W-1:0]             cmd_tgt;
    logic [WORD_W-1:0]             cmd_wd;

    // Response classification
    logic                          rsp_crc, rsp_err, rsp_good, busy;
    logic [N_CH-1:0]               pend_next;

    settle_timer #(.CYCLES(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_SETTLE),
        .fire  (settle_fire)
    );

    chan_pick #(.N(N_CH)) u_pick (
        .pend  (pend),
        .grant (grant),
        .idx   (idx)
    );

    assign rsp_crc   = xact_crc_err;
    assign rsp_err   = !xact_crc_err && (xact_rs == RS_ERROR);
    assign rsp_good  = !xact_crc_err && (xact_rs != RS_ERROR);
    assign busy      = (state != ST_IDLE) && (state != ST_DEAD);
    assign pend_next = pend & ~grant;
    assign op        = cmd_op_t'(cmd_op);
    assign smp_data  = smp_q;

    // Drive the transactor request fields from the current state.
    always_comb begin
        xact_req   = 1'b0;
        xact_wr    = 1'b0;
        xact_addr  = '0;
        xact_wdata = '0;
        case (state)
            ST_BOOT:  begin xact_req = 1'b1; xact_wr = 1'b1; xact_addr = A_MODE; xact_wdata = SOFT_RST_CODE; end
            ST_IDENT: begin xact_req = 1'b1; xact_addr = A_IDENT; end
            ST_SCAN:  begin xact_req = 1'b1; xact_addr = ADDR_W'(CH_BASE + int'(idx)); end
            ST_CMD:   begin xact_req = 1'b1; xact_wr = 1'b1; xact_addr = cmd_tgt_q; xact_wdata = cmd_wd_q; end
            ST_STAT:  begin xact_req = 1'b1; xact_addr = A_STAT; end
            default:  ;
        endcase
    end

    // Decide whether the presented command is allowed and what it writes.
    always_comb begin
        cmd_ok  = 1'b0;
        cmd_tgt = cmd_addr[ADDR_W-1:0];
        cmd_wd  = cmd_data;
        case (op)
            OP_REGWR: cmd_ok = (cmd_addr <= 8'h1F);
            OP_MODE: begin
                cmd_tgt = A_MODE;
                cmd_ok  = (cmd_data <= 16'd3);
            end
            OP_FILT: begin
                cmd_tgt = A_MODE;
                cmd_wd  = cmd_data[0] ? 16'd3 : 16'd2;
                cmd_ok  = cmd_data[0] ? (mode_q == 2'd2) : (mode_q == 2'd3);
            end
            default: cmd_ok = 1'b0;
        endcase
    end

    // Main sequencer: state transitions, records, flags and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_BOOT;
            pend       <= '0;
            smp_q      <= '0;
            mode_q     <= 2'd0;
            cmd_tgt_q  <= '0;
            cmd_wd_q   <= '0;
            init_ok    <= 1'b0;
            init_fail  <= 1'b0;
            smp_valid  <= 1'b0;
            err_valid  <= 1'b0;
            err_status <= '0;
            cmd_done   <= 1'b0;
            cmd_rej    <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            err_valid <= 1'b0;
            cmd_done  <= 1'b0;
            cmd_rej   <= 1'b0;
            case (state)
                ST_BOOT: if (xact_done) begin
                    if (rsp_crc) begin
                        init_fail <= 1'b1;
                        state     <= ST_DEAD;
                    end else begin
                        state <= ST_SETTLE;
                    end
                end
                ST_SETTLE: if (settle_fire) state <= ST_IDENT;
                ST_IDENT: if (xact_done) begin
                    if (rsp_good && xact_rdata[7:0] == IDENT_CODE) begin
                        init_ok <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        init_fail <= 1'b1;
                        state     <= ST_DEAD;
                    end
                end
                ST_IDLE: begin
                    if (trig && chan_en != '0) begin
                        pend  <= chan_en;
                        smp_q <= '0;
                        state <= ST_SCAN;
                    end else if (cmd_valid) begin
                        if (cmd_ok) begin
                            cmd_tgt_q <= cmd_tgt;
                            cmd_wd_q  <= cmd_wd;
                            state     <= ST_CMD;
                        end else begin
                            cmd_rej <= 1'b1;
                        end
                    end
                end
                ST_SCAN: if (xact_done) begin
                    if (rsp_crc) begin
                        state <= ST_IDLE;
                    end else if (rsp_err) begin
                        state <= ST_STAT;
                    end else begin
                        for (int i = 0; i < N_CH; i++)
                            if (grant[i]) smp_q[i] <= xact_rdata;
                        pend <= pend_next;
                        if (pend_next == '0) begin
                            smp_valid <= 1'b1;
                            state     <= ST_IDLE;
                        end
                    end
                end
                ST_CMD: if (xact_done) begin
                    cmd_done <= 1'b1;
                    if (rsp_err) begin
                        state <= ST_STAT;
                    end else begin
                        if (rsp_good && cmd_tgt_q == A_MODE && cmd_wd_q <= 16'd3)
                            mode_q <= cmd_wd_q[1:0];
                        state <= ST_IDLE;
                    end
                end
                ST_STAT: if (xact_done) begin
                    err_valid  <= 1'b1;
                    err_status <= xact_rdata[STAT_W-1:0];
                    state      <= ST_IDLE;
                end
                default: state <= ST_DEAD;
            endcase
        end
    end

    // Count triggers that arrive while the sequencer is occupied; saturate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun_cnt <= '0;
        else if (trig && busy && overrun_cnt != {OVR_W{1'b1}})
            overrun_cnt <= overrun_cnt + 1'b1;
    end

    // R3: ready and failed indications never coexist
    a_r3_ok_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_ok && init_fail));

    // R7: the overrun count never goes down
    a_r7_overrun_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_cnt >= $past(overrun_cnt));

    // R5: a record strobe and an error report never share a cycle
    a_r5_sample_or_error: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && err_valid));

    // R4: the picker grants at most one channel at a time
    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8: a request stays up with a steady target until it is completed
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_req && !xact_done) |=> (xact_req && $stable(xact_addr) && $stable(xact_wr)));
endmodule

// File: tb/sensor_seq_test.sv
module sensor_seq_test;
    localparam int N_CH = 4;
    localparam int CLK_KHZ = 2;
    localparam int SETTLE_MS = 16;
    localparam int WAIT_CYC = CLK_KHZ * SETTLE_MS;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic [N_CH-1:0] chan_en = '0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [7:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic cmd_done, cmd_rej;
    logic xact_req, xact_wr;
    logic [4:0] xact_addr;
    logic [15:0] xact_wdata;
    logic xact_done = 1'b0;
    logic [1:0] xact_rs = '0;
    logic [15:0] xact_rdata = '0;
    logic xact_crc_err = 1'b0;
    logic init_ok, init_fail, smp_valid, err_valid;
    logic [16*N_CH-1:0] smp_data;
    logic [8:0] err_status;
    logic [7:0] overrun_cnt;

    sensor_seq #(.N_CH(N_CH), .CH_BASE(1), .CLK_KHZ(CLK_KHZ), .SETTLE_MS(SETTLE_MS), .OVR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .chan_en(chan_en),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_done(cmd_done), .cmd_rej(cmd_rej),
        .xact_req(xact_req), .xact_wr(xact_wr), .xact_addr(xact_addr), .xact_wdata(xact_wdata),
        .xact_done(xact_done), .xact_rs(xact_rs), .xact_rdata(xact_rdata), .xact_crc_err(xact_crc_err),
        .init_ok(init_ok), .init_fail(init_fail), .smp_valid(smp_valid), .smp_data(smp_data),
        .err_valid(err_valid), .err_status(err_status), .overrun_cnt(overrun_cnt)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    // Device model knobs
    int id_val = 'h51, stat_val = 'hF2A5, scan_k = 0;
    int inj_rs3 = -1, inj_crc = -1;

    // Access log
    int log_n = 0;
    int log_addr [0:255];
    int log_wr   [0:255];
    int log_wd   [0:255];
    int log_t    [0:255];

    // Observed pulses
    int n_smp = 0, n_err = 0, n_done = 0, n_rej = 0;
    logic [16*N_CH-1:0] last_smp = '0;
    int last_err = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Transactor model: accept, wait LAT cycles, answer, then leave a gap cycle.
    initial begin
        int phase = 0, cnt = 0, a = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (!rst_n) begin
                phase = 0;
                xact_done <= 1'b0;
            end else begin
                case (phase)
                    0: if (xact_req === 1'b1) begin
                        a = int'(xact_addr);
                        if (log_n < 256) begin
                            log_addr[log_n] = a;
                            log_wr[log_n] = int'(xact_wr);
                            log_wd[log_n] = int'(xact_wdata);
                            log_t[log_n] = cyc;
                        end
                        log_n++;
                        cnt = LAT;
                        phase = 1;
                    end
                    1: if (cnt > 1) cnt--;
                       else begin
                        xact_done <= 1'b1;
                        xact_crc_err <= 1'b0;
                        xact_rs <= 2'd1;
                        xact_rdata <= 16'h0;
                        if (a == 'h10) xact_rdata <= 16'(id_val);
                        else if (a == 'h06) begin xact_rdata <= 16'(stat_val); xact_rs <= 2'd3; end
                        else if (a >= 1 && a <= N_CH && log_wr[(log_n - 1) % 256] == 0)
                            xact_rdata <= {4'(a), 12'(scan_k)};
                        if (a == inj_rs3) begin xact_rs <= 2'd3; inj_rs3 = -1; end
                        if (a == inj_crc) begin xact_crc_err <= 1'b1; inj_crc = -1; end
                        phase = 2;
                    end
                    default: begin
                        xact_done <= 1'b0;
                        phase = 0;
                    end
                endcase
            end
        end
    end

    // Pulse monitor, sampled away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (smp_valid === 1'b1) begin n_smp++; last_smp = smp_data; end
            if (err_valid === 1'b1) begin n_err++; last_err = int'(err_status); end
            if (cmd_done === 1'b1) n_done++;
            if (cmd_rej === 1'b1) n_rej++;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic pulse_trig(input logic [N_CH-1:0] m);
        @(negedge clk);
        chan_en = m;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic do_cmd(input int op, input int addr, input int data);
        int d0, r0;
        d0 = n_done; r0 = n_rej;
        @(negedge clk);
        cmd_op = 2'(op); cmd_addr = 8'(addr); cmd_data = 16'(data);
        cmd_valid = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            #1;
            if (n_done != d0 || n_rej != r0) break;
        end
        cmd_valid = 1'b0;
        wait_cyc(20);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(5);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        wait_cyc(20000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s, ls, ln, pc, ov0, na;
        logic [16*N_CH-1:0] exp;
        bit ordok;

        // R11: reset values
        rst_n = 1'b0;
        wait_cyc(4);
        check(init_ok === 1'b0 && init_fail === 1'b0, "R11 init flags in reset", {init_ok, init_fail}, 0);
        check(overrun_cnt === 8'd0 && smp_valid === 1'b0 && err_valid === 1'b0, "R11 counters in reset", overrun_cnt, 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(1);
        check(init_ok === 1'b0 && init_fail === 1'b0, "R11 flags after release", {init_ok, init_fail}, 0);

        // R1..R3 startup
        wait_cyc(WAIT_CYC + 30);
        check(log_n == 2, "R1 startup access count", log_n, 2);
        check(log_addr[0] == 'h0D && log_wr[0] == 1 && log_wd[0] == 'h20, "R1 soft reset write", log_wd[0], 'h20);
        check(log_t[1] - log_t[0] >= WAIT_CYC + 3 && log_t[1] - log_t[0] <= WAIT_CYC + 5,
              "R2 settle spacing", log_t[1] - log_t[0], WAIT_CYC + 4);
        check(log_addr[1] == 'h10 && log_wr[1] == 0, "R3 identity read", log_addr[1], 'h10);
        check(init_ok === 1'b1 && init_fail === 1'b0, "R3 ready flag", init_ok, 1);

        // R4: sweep all channel masks
        for (int m = 0; m < 16; m++) begin
            scan_k = 'h100 + m * 7;
            s = n_smp; ls = log_n;
            pulse_trig(4'(m));
            wait_cyc(60);
            pc = $countones(4'(m));
            if (m == 0) begin
                check(n_smp == s && log_n == ls, "R4 empty mask ignored", log_n - ls, 0);
            end else begin
                check(n_smp == s + 1, "R4 one record strobe", n_smp - s, 1);
                check(log_n - ls == pc, "R4 reads per mask", log_n - ls, pc);
                ordok = 1; na = ls;
                for (int i = 0; i < N_CH; i++)
                    if (m[i]) begin
                        if (log_addr[na] != i + 1 || log_wr[na] != 0) ordok = 0;
                        na++;
                    end
                check(ordok, "R4 ascending order", m, m);
                exp = '0;
                for (int i = 0; i < N_CH; i++)
                    if (m[i]) exp[16*i +: 16] = {4'(i + 1), 12'(scan_k)};
                check(last_smp == exp, "R4 record contents", last_smp, exp);
            end
        end

        // R7: triggers during a scan are dropped and counted
        ov0 = int'(overrun_cnt); s = n_smp; ls = log_n;
        pulse_trig(4'hF);
        wait_cyc(2);
        pulse_trig(4'hF);
        wait_cyc(2);
        pulse_trig(4'hF);
        wait_cyc(60);
        check(int'(overrun_cnt) == ov0 + 2, "R7 overrun count", overrun_cnt, ov0 + 2);
        check(n_smp == s + 1 && log_n - ls == 4, "R7 dropped triggers start nothing", log_n - ls, 4);

        // R5: status-3 return mid scan
        s = n_smp; ls = log_n; inj_rs3 = 2; stat_val = 'hF2A5;
        pulse_trig(4'h7);
        wait_cyc(60);
        check(n_smp == s, "R5 no record after error", n_smp - s, 0);
        check(log_n - ls == 3 && log_addr[ls + 2] == 'h06, "R5 status read replaces channel", log_addr[ls + 2], 'h06);
        check(last_err == 'h0A5, "R5 reported status", last_err, 'h0A5);

        // R6: checksum failure mid scan
        s = n_smp; ls = log_n; ln = n_err; inj_crc = 3;
        pulse_trig(4'hF);
        wait_cyc(60);
        check(n_smp == s && n_err == ln, "R6 no record no report", n_smp - s + n_err - ln, 0);
        check(log_n - ls == 3 && log_addr[ls + 2] == 3, "R6 no status read", log_n - ls, 3);

        // R4: normal scan after errors
        s = n_smp; scan_k = 'hABC;
        pulse_trig(4'h9);
        wait_cyc(60);
        exp = '0; exp[15:0] = 16'h1ABC; exp[63:48] = 16'h4ABC;
        check(n_smp == s + 1 && last_smp == exp, "R4 scan after errors", last_smp, exp);

        // R8: register writes
        ls = log_n; s = n_rej;
        do_cmd(0, 'h25, 'h1111);
        check(n_rej == s + 1 && log_n == ls, "R8 address above 0x1F rejected", log_n - ls, 0);
        ls = log_n; s = n_done;
        do_cmd(0, 'h1F, 'h1234);
        check(n_done == s + 1 && log_n == ls + 1 && log_addr[ls] == 'h1F && log_wr[ls] == 1 && log_wd[ls] == 'h1234,
              "R8 write issued", log_wd[ls], 'h1234);
        ls = log_n; s = n_rej;
        do_cmd(3, 'h01, 0);
        check(n_rej == s + 1 && log_n == ls, "R8 reserved op rejected", log_n - ls, 0);

        // R9 / R10: mode and filter
        ls = log_n; s = n_rej;
        do_cmd(1, 0, 5);
        check(n_rej == s + 1 && log_n == ls, "R9 mode value 5 rejected", log_n - ls, 0);
        ls = log_n; s = n_rej;
        do_cmd(2, 0, 1);
        check(n_rej == s + 1 && log_n == ls, "R10 filter refused in mode 0", log_n - ls, 0);
        ls = log_n;
        do_cmd(1, 0, 2);
        check(log_n == ls + 1 && log_addr[ls] == 'h0D && log_wd[ls] == 2, "R9 mode 2 written", log_wd[ls], 2);
        ls = log_n;
        do_cmd(2, 0, 1);
        check(log_n == ls + 1 && log_addr[ls] == 'h0D && log_wd[ls] == 3, "R10 low cutoff from mode 2", log_wd[ls], 3);
        ls = log_n; s = n_rej;
        do_cmd(2, 0, 1);
        check(n_rej == s + 1 && log_n == ls, "R10 low cutoff refused in mode 3", log_n - ls, 0);
        ls = log_n;
        do_cmd(2, 0, 0);
        check(log_n == ls + 1 && log_wd[ls] == 2, "R10 high cutoff from mode 3", log_wd[ls], 2);
        ls = log_n; ln = n_err; inj_rs3 = 'h0D; stat_val = 'h01FF;
        do_cmd(1, 0, 3);
        wait_cyc(20);
        check(log_n == ls + 2 && log_addr[ls + 1] == 'h06 && n_err == ln + 1 && last_err == 'h1FF,
              "R5 failed command reads status", last_err, 'h1FF);
        ls = log_n; s = n_rej;
        do_cmd(2, 0, 0);
        check(n_rej == s + 1 && log_n == ls, "R10 mode unchanged by failed write", log_n - ls, 0);

        // R3: identity mismatch locks the failed state
        id_val = 'h52;
        do_reset();
        wait_cyc(WAIT_CYC + 30);
        check(init_fail === 1'b1 && init_ok === 1'b0, "R3 wrong identity fails", init_fail, 1);
        ls = log_n; s = n_smp; ov0 = int'(overrun_cnt);
        pulse_trig(4'hF);
        wait_cyc(30);
        check(log_n == ls && n_smp == s, "R3 trigger ignored after failure", log_n - ls, 0);
        check(int'(overrun_cnt) == ov0, "R7 no overrun count when failed", overrun_cnt, ov0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule